// File: doc/BRIEF.md
# Shaper Rate Register Update Sequencer

This block stands between a configuration request port and the register bus of a multi-level transmit scheduler. Each request names a scheduler level, a packed register address, a new 64-bit value and a keep-mask. The block reads the register's current contents and merges in the new value under the mask. It then checks whether the target is a committed-rate or peak-rate register whose enable bit is about to flip. Such a change must not reach the hardware while traffic is flowing, so the block parks the queue with its transmit-off control first. On a disable it waits a fixed settle time before releasing the queue. On an enable it first polls the queue's debug status until the shaper is ready, with a time limit.

Every other write, and every write when the capability input is low, goes to the bus as a plain read-merge-write. The outcome comes back on a response channel as done or as a timeout error. The request and response channels are valid/ready. A request is taken only while the block is idle, so only one request is in flight. A response stays presented, with its error flag unchanged, for as long as `rsp_ready` is held low.

Top module: `shaper_upd_seq`

## Requirements
- R1: The bus address is the request address bits [25:0]: bits [25:16] are the queue index and bits [15:0] the register offset. Request address bits above 25 have no effect on any bus transfer.
- R2: Every request starts with a bus read of the target. Any data written to the target is (old & keep) | (new & ~keep), so an all-zero keep-mask writes the new value unchanged.
- R3: Levels are encoded 0 = meta-descriptor queue, 1..3 = intermediate, 4 = top. A register offset is {1'b0, level[2:0], sub[11:0]}, with sub 0x010 for committed rate, 0x020 for peak rate, 0x030 for transmit-off and 0x040 for debug status. Committed rate is a rate register at levels 0..4, and peak rate only at levels 0..3. A top-level peak write is a plain write.
- R4: If the rate enable bit (bit 0) of the old and merged values is equal, the block makes one write of the merged value and no transmit-off access.
- R5: When a rate is disabled, the block writes, in order: 1 to the queue's transmit-off register, 0 to the rate register, and then, after at least SETTLE_US×CYC_PER_US cycles, 0 to transmit-off. It then responds with no error.
- R6: When a rate is enabled at levels 1..4, the block writes 1 to transmit-off and then reads the queue's status register. The reads repeat, at least POLL_GAP idle cycles apart, until bit 32 is 1 or bit 48 is 0. It then writes the merged value and writes 0 to transmit-off.
- R7: If the poll is still unsatisfied once TIMEOUT_US×CYC_PER_US cycles have passed since transmit-off was set, the rate register is not written. Transmit-off is still written 0, and the response carries the error flag.
- R8: When a rate is enabled at level 0, the block skips the poll: it writes transmit-off 1, then the merged value, then transmit-off 0.
- R9: A write to a register that is not a rate register is a read followed by a single merged write.
- R10: With `toggle_wait_en` low, every request is a read followed by a single merged write, even when a rate enable bit changes.
- R11: `req_ready` is high only when no request is in progress. `rsp_valid` holds, with `rsp_err` stable, until `rsp_ready`, and rises the cycle after the final bus acknowledge.
- R12: A bus request keeps its address, direction and write data until `bus_ack`. The first bus read is presented the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| toggle_wait_en | input | 1 | Capability: use guarded sequence for rate enable changes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_level | input | 3 | Scheduler level of the target |
| req_addr | input | REQ_AW | Packed register address |
| req_data | input | 64 | New value |
| req_keep | input | 64 | Keep-mask: 1 keeps the old bit |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted when high with rsp_valid |
| rsp_err | output | 1 | Status poll timed out |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 26 | Register bus address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge, completes the transfer |
| bus_rdata | input | 64 | Read data, valid with bus_ack |

## Verification
The first bus read is due in the cycle after acceptance. Each later transfer is due in order once the previous acknowledge completes, and the response is due in the cycle after the final acknowledge. The settle wait, the poll spacing and the timeout are lower bounds measured between acknowledge cycles. The bench drives inputs just after the rising edge and samples at the falling edge. Its memory-backed bus model compares every transfer against an expected list built from the requirements. A per-cycle monitor tracks whether a request is open and checks `req_ready`, the first-read cycle, the response cycle and response hold against that state.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int BUS_AW = 26;
  localparam int QIDX_LSB = 16;
  localparam int DATA_W = 64;
  localparam int EN_BIT = 0;
  localparam int VLD_BIT = 32;
  localparam int PEND_BIT = 48;

  localparam logic [2:0] LVL_MDQ = 3'd0;
  localparam logic [2:0] LVL_TOP = 3'd4;

  localparam logic [11:0] SUB_CRATE = 12'h010;
  localparam logic [11:0] SUB_PRATE = 12'h020;
  localparam logic [11:0] SUB_XOFF  = 12'h030;
  localparam logic [11:0] SUB_STAT  = 12'h040;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OLD, S_DECIDE, S_WR_DIRECT, S_DIS_XOFF, S_DIS_ZERO,
    S_DIS_WAIT, S_EN_XOFF, S_POLL_RD, S_POLL_GAP, S_EN_WR, S_XON, S_RESP
  } shp_state_e;

  function automatic logic [15:0] reg_off(input logic [2:0] lvl, input logic [11:0] sub);
    return {1'b0, lvl, sub};
  endfunction
endpackage

// File: rtl/shp_cycle_timer.sv
module shp_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)             count <= '0;
    else if (load)          count <= W'(LIMIT);
    else if (count != '0)   count <= count - W'(1);
  end

  assign done = (count == '0);

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == W'(LIMIT)));  // R5
endmodule

// File: rtl/shp_reg_classify.sv
module shp_reg_classify
  import shp_pkg::*;
(
  input  logic [2:0]        level,
  input  logic [BUS_AW-1:0] addr,
  output logic              is_rate,
  output logic              has_status,
  output logic [BUS_AW-1:0] xoff_addr,
  output logic [BUS_AW-1:0] stat_addr
);
  logic [15:0] off;
  logic [9:0]  qidx;
  logic        lvl_ok;
  logic        lvl_mid;

  assign off  = addr[QIDX_LSB-1:0];
  assign qidx = addr[BUS_AW-1:QIDX_LSB];

  always_comb begin
    lvl_ok  = (level <= LVL_TOP);
    lvl_mid = (level < LVL_TOP);
    is_rate = (lvl_ok  && off == reg_off(level, SUB_CRATE)) ||
              (lvl_mid && off == reg_off(level, SUB_PRATE));
    has_status = lvl_ok && (level != LVL_MDQ);
    xoff_addr  = {qidx, reg_off(level, SUB_XOFF)};
    stat_addr  = {qidx, reg_off(level, SUB_STAT)};
  end
endmodule

// File: rtl/shaper_upd_seq.sv
module shaper_upd_seq
  import shp_pkg::*;
#(
  parameter int REQ_AW     = 32,
  parameter int CYC_PER_US = 125,
  parameter int SETTLE_US  = 4,
  parameter int TIMEOUT_US = 10000,
  parameter int POLL_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              toggle_wait_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_level,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic [63:0]       req_keep,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [25:0]       bus_addr,
  output logic [63:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [63:0]       bus_rdata
);
  localparam int SETTLE_CYC  = CYC_PER_US * SETTLE_US;
  localparam int TIMEOUT_CYC = CYC_PER_US * TIMEOUT_US;

  shp_state_e        state;
  logic [2:0]        lvl_q;
  logic [BUS_AW-1:0] addr_q;
  logic [63:0]       new_q;
  logic [63:0]       keep_q;
  logic [63:0]       old_q;
  logic [63:0]       merged;
  logic              err_q;
  logic              guard_q;

  logic              is_rate;
  logic              has_status;
  logic [BUS_AW-1:0] xoff_addr;
  logic [BUS_AW-1:0] stat_addr;

  logic settle_load, settle_done;
  logic tmo_load, tmo_done;
  logic gap_load, gap_done;
  logic poll_ok;
  logic guarded;
  logic unused_addr_hi;

  generate
    if (REQ_AW > BUS_AW) begin : g_hi
      assign unused_addr_hi = ^req_addr[REQ_AW-1:BUS_AW];
    end else begin : g_no_hi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  shp_reg_classify u_cls (
    .level      (lvl_q),
    .addr       (addr_q),
    .is_rate    (is_rate),
    .has_status (has_status),
    .xoff_addr  (xoff_addr),
    .stat_addr  (stat_addr)
  );

  shp_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .done(settle_done));
  shp_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(tmo_load), .done(tmo_done));
  shp_cycle_timer #(.LIMIT(POLL_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .done(gap_done));

  assign merged  = (old_q & keep_q) | (new_q & ~keep_q);
  assign guarded = toggle_wait_en && is_rate && (old_q[EN_BIT] != merged[EN_BIT]);
  assign poll_ok = bus_rdata[VLD_BIT] || !bus_rdata[PEND_BIT];

  assign settle_load = (state == S_DIS_ZERO) && bus_ack;
  assign tmo_load    = (state == S_EN_XOFF) && bus_ack && has_status;
  assign gap_load    = (state == S_POLL_RD) && bus_ack && !poll_ok && !tmo_done;

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_err   = err_q;

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = addr_q;
    bus_wdata = '0;
    unique case (state)
      S_RD_OLD:    bus_we = 1'b0;
      S_WR_DIRECT: bus_wdata = merged;
      S_DIS_XOFF,
      S_EN_XOFF: begin
        bus_addr  = xoff_addr;
        bus_wdata = 64'd1;
      end
      S_DIS_ZERO:  bus_wdata = '0;
      S_POLL_RD: begin
        bus_we   = 1'b0;
        bus_addr = stat_addr;
      end
      S_EN_WR:     bus_wdata = merged;
      S_XON:       bus_addr = xoff_addr;
      default: begin
        bus_req = 1'b0;
        bus_we  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      new_q   <= '0;
      keep_q  <= '0;
      old_q   <= '0;
      err_q   <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          lvl_q   <= req_level;
          addr_q  <= req_addr[BUS_AW-1:0];
          new_q   <= req_data;
          keep_q  <= req_keep;
          err_q   <= 1'b0;
          guard_q <= 1'b0;
          state   <= S_RD_OLD;
        end
        S_RD_OLD: if (bus_ack) begin
          old_q <= bus_rdata;
          state <= S_DECIDE;
        end
        S_DECIDE: begin
          guard_q <= guarded;
          if (!guarded)             state <= S_WR_DIRECT;
          else if (!merged[EN_BIT]) state <= S_DIS_XOFF;
          else                      state <= S_EN_XOFF;
        end
        S_WR_DIRECT: if (bus_ack) state <= S_RESP;
        S_DIS_XOFF:  if (bus_ack) state <= S_DIS_ZERO;
        S_DIS_ZERO:  if (bus_ack) state <= S_DIS_WAIT;
        S_DIS_WAIT:  if (settle_done) state <= S_XON;
        S_EN_XOFF:   if (bus_ack) state <= has_status ? S_POLL_RD : S_EN_WR;
        S_POLL_RD: if (bus_ack) begin
          if (poll_ok) state <= S_EN_WR;
          else if (tmo_done) begin
            err_q <= 1'b1;
            state <= S_XON;
          end else state <= S_POLL_GAP;
        end
        S_POLL_GAP: if (gap_done) state <= S_POLL_RD;
        S_EN_WR:    if (bus_ack) state <= S_XON;
        S_XON:      if (bus_ack) state <= S_RESP;
        S_RESP:     if (rsp_ready) state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  // Tracks whether the guarded sequence left a queue parked.
  logic xoff_held;
  always_ff @(posedge clk) begin
    if (!rst_n) xoff_held <= 1'b0;
    else if (guard_q && bus_req && bus_ack && bus_we && bus_addr == xoff_addr)
      xoff_held <= bus_wdata[0];
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));  // R12
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err)));  // R11
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R11
  AST_XOFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !xoff_held);  // R5
  AST_NO_RATE_WRITE_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && bus_req && bus_we) |-> (bus_addr != addr_q));  // R7
endmodule

// File: tb/sim_shaper_upd_seq.sv
module sim_shaper_upd_seq;
  localparam int CPU = 4;
  localparam int SET_US = 4;
  localparam int TMO_US = 25;
  localparam int GAP = 3;
  localparam int SETTLE_CYC = CPU * SET_US;
  localparam int TMO_CYC = CPU * TMO_US;

  typedef struct packed {
    logic        we;
    logic        wild;
    logic [25:0] addr;
    logic [63:0] data;
  } txn_t;

  typedef struct packed {
    int          cyc;
    logic        we;
    logic [25:0] addr;
    logic [63:0] data;
  } log_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        toggle_wait_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_level = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic [63:0] req_keep = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_err;
  logic        bus_req;
  logic        bus_we;
  logic [25:0] bus_addr;
  logic [63:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [63:0] bus_rdata = '0;

  always #4 clk = ~clk;

  shaper_upd_seq #(
    .REQ_AW(32), .CYC_PER_US(CPU), .SETTLE_US(SET_US),
    .TIMEOUT_US(TMO_US), .POLL_GAP(GAP)
  ) u0 (.*);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [63:0] mem [logic [25:0]];
  txn_t expq[$];
  log_t txlog[$];
  int   n_txn = 0;
  int   lat_cnt = 0;
  int   stat_reads = 0;
  int   stat_ready_after = 0;
  bit   stat_pend_clear = 1'b0;
  bit   cur_exp_err = 1'b0;
  string cur_tag = "R2";

  bit busy = 1'b0;
  bit acc_prev = 1'b0;
  bit rsp_due = 1'b0;
  bit rsp_seen = 1'b0;
  bit stall_prev = 1'b0;
  bit err_prev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input logic [9:0] q, input logic [2:0] lvl,
                                     input logic [11:0] sub);
    return {q, 1'b0, lvl, sub};
  endfunction

  function automatic logic [63:0] mem_rd(input logic [25:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) cyc++;

  // Register bus model with 0..2 cycles of latency.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      bus_ack = 1'b0;
      lat_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      lat_cnt = n_txn % 3;
    end else if (bus_req) begin
      if (lat_cnt > 0) lat_cnt--;
      else begin
        serve();
        bus_ack = 1'b1;
      end
    end
  end

  task automatic serve();
    logic [25:0] a;
    log_t le;
    bit ok;
    a = bus_addr;
    le.cyc = cyc; le.we = bus_we; le.addr = a; le.data = bus_wdata;
    txlog.push_back(le);
    n_txn++;
    if (bus_we) mem[a] = bus_wdata;
    else if (a[11:0] == 12'h040) begin
      if (stat_pend_clear) bus_rdata = 64'd0;
      else if (stat_reads >= stat_ready_after) bus_rdata = (64'd1 << 32) | (64'd1 << 48);
      else bus_rdata = 64'd1 << 48;
      stat_reads++;
    end else bus_rdata = mem_rd(a);
    while (expq.size() > 0 && expq[0].wild && !(!bus_we && expq[0].addr == a))
      void'(expq.pop_front());
    if (expq.size() == 0)
      check(1'b0, "R12", "unexpected bus transfer at addr", {38'd0, a}, 64'd0);
    else if (!expq[0].wild) begin
      ok = (expq[0].we == bus_we) && (expq[0].addr == a) &&
           (!bus_we || expq[0].data == bus_wdata);
      check(ok, cur_tag, $sformatf("bus transfer we=%0d addr=%h (exp we=%0d addr=%h)",
            bus_we, a, expq[0].we, expq[0].addr), bus_wdata, expq[0].data);
      void'(expq.pop_front());
    end
  endtask

  // Per-cycle monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == !busy, "R11", "req_ready against open request", {63'd0, req_ready}, {63'd0, !busy});
      if (acc_prev)
        check(bus_req && !bus_we, "R12", "read presented cycle after accept",
              {62'd0, bus_req, bus_we}, 64'd2);
      if (rsp_due)
        check(rsp_valid, "R11", "response cycle after final ack", {63'd0, rsp_valid}, 64'd1);
      if (stall_prev)
        check(rsp_valid && rsp_err == err_prev, "R11", "response held under back-pressure",
              {62'd0, rsp_valid, rsp_err}, {62'd0, 1'b1, err_prev});
      if (rsp_valid && !rsp_seen) begin
        check(rsp_err == cur_exp_err, cur_tag, "response error flag",
              {63'd0, rsp_err}, {63'd0, cur_exp_err});
        rsp_seen = 1'b1;
      end
      acc_prev   = req_valid && req_ready;
      stall_prev = rsp_valid && !rsp_ready;
      err_prev   = rsp_err;
      rsp_due    = bus_ack && busy && (expq.size() == 0);
      if (acc_prev) begin
        busy = 1'b1;
        rsp_seen = 1'b0;
      end
      if (rsp_valid && rsp_ready) busy = 1'b0;
    end
  end

  task automatic push_t(input bit we, input bit wild, input logic [25:0] a, input logic [63:0] d);
    txn_t t;
    t.we = we; t.wild = wild; t.addr = a; t.data = d;
    expq.push_back(t);
  endtask

  // Expected transfer list, built from the requirements.
  task automatic build_expect(input logic [2:0] lvl, input logic [31:0] addr,
                              input logic [63:0] data, input logic [63:0] keep,
                              input bit cap, input bit tmo);
    logic [25:0] a, xa, sa;
    logic [63:0] old, mrg;
    logic [11:0] sub;
    bit rate;
    a = addr[25:0];
    sub = a[11:0];
    old = mem_rd(a);
    mrg = (old & keep) | (data & ~keep);
    rate = (a[15:12] == {1'b0, lvl}) &&
           ((sub == 12'h010 && lvl <= 3'd4) || (sub == 12'h020 && lvl <= 3'd3));
    xa = mk(a[25:16], lvl, 12'h030);
    sa = mk(a[25:16], lvl, 12'h040);
    cur_exp_err = 1'b0;
    push_t(1'b0, 1'b0, a, 64'd0);
    if (!cap || !rate || old[0] == mrg[0]) push_t(1'b1, 1'b0, a, mrg);
    else if (!mrg[0]) begin
      push_t(1'b1, 1'b0, xa, 64'd1);
      push_t(1'b1, 1'b0, a, 64'd0);
      push_t(1'b1, 1'b0, xa, 64'd0);
    end else begin
      push_t(1'b1, 1'b0, xa, 64'd1);
      if (lvl != 3'd0) begin
        if (tmo) begin
          push_t(1'b0, 1'b1, sa, 64'd0);
          cur_exp_err = 1'b1;
        end else begin
          for (int i = 0; i < (stat_pend_clear ? 1 : stat_ready_after + 1); i++)
            push_t(1'b0, 1'b0, sa, 64'd0);
        end
      end
      if (!cur_exp_err) push_t(1'b1, 1'b0, a, mrg);
      push_t(1'b1, 1'b0, xa, 64'd0);
    end
  endtask

  task automatic run_req(input logic [2:0] lvl, input logic [31:0] addr,
                         input logic [63:0] data, input logic [63:0] keep,
                         input bit cap, input bit tmo, input int hold, input string tag);
    bit hs;
    cur_tag = tag;
    stat_reads = 0;
    txlog.delete();
    build_expect(lvl, addr, data, keep, cap, tmo);
    @(posedge clk); #1;
    toggle_wait_en = cap;
    req_level = lvl; req_addr = addr; req_data = data; req_keep = keep;
    req_valid = 1'b1;
    if (hold > 0) rsp_ready = 1'b0;
    do begin
      @(negedge clk);
      hs = req_ready;
      @(posedge clk); #1;
    end while (!hs);
    req_valid = 1'b0;
    if (hold > 0) begin
      do @(negedge clk); while (!rsp_valid);
      repeat (hold) @(negedge clk);
      @(posedge clk); #1;
      rsp_ready = 1'b1;
    end
    do @(negedge clk); while (!(rsp_valid && rsp_ready));
    @(posedge clk); #1;
    check(expq.size() == 0, tag, "all expected transfers seen", expq.size(), 64'd0);
    expq.delete();
  endtask

  function automatic int find_log(input bit we, input logic [25:0] a, input logic [63:0] d, input int from);
    for (int i = from; i < txlog.size(); i++)
      if (txlog[i].we == we && txlog[i].addr == a && (!we || txlog[i].data == d)) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [25:0] a;
    int i0, i1, gap_min;
    repeat (5) @(posedge clk);
    #1;
    check(req_ready && !bus_req && !rsp_valid, "R11", "reset state",
          {61'd0, req_ready, bus_req, rsp_valid}, 64'd4);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R9 and R2: non-rate register, zero keep-mask replaces
    a = mk(10'h003, 3'd2, 12'h050);
    mem[a] = 64'hFFFF_0000_1234_5671;
    run_req(3'd2, {6'd0, a}, 64'h0A0B_0C0D_0000_0000, 64'd0, 1'b1, 1'b0, 0, "R9");
    check(mem_rd(a) == 64'h0A0B_0C0D_0000_0000, "R2", "zero keep replaces", mem_rd(a), 64'h0A0B_0C0D_0000_0000);

    // R2: partial keep-mask
    a = mk(10'h007, 3'd1, 12'h060);
    mem[a] = 64'h1111_2222_3333_4444;
    run_req(3'd1, {6'd0, a}, 64'hAAAA_BBBB_CCCC_DDDD, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 0, "R2");
    check(mem_rd(a) == 64'h1111_2222_CCCC_DDDD, "R2", "merged value", mem_rd(a), 64'h1111_2222_CCCC_DDDD);

    // R1: upper address bits dropped
    a = mk(10'h155, 3'd3, 12'h070);
    run_req(3'd3, {6'h3F, a}, 64'h55, 64'd0, 1'b1, 1'b0, 0, "R1");
    check(txlog.size() > 0 && txlog[0].addr == a, "R1", "bus address from bits 25:0",
          txlog.size() > 0 ? {38'd0, txlog[0].addr} : 64'd0, {38'd0, a});

    // R4: rate register with unchanged enable bit
    a = mk(10'h005, 3'd3, 12'h010);
    mem[a] = 64'h1001;
    run_req(3'd3, {6'd0, a}, 64'h2001, 64'd0, 1'b1, 1'b0, 0, "R4");
    check(txlog.size() == 2, "R4", "direct write only", txlog.size(), 64'd2);

    // R5: disable sequence with settle wait
    run_req(3'd3, {6'd0, a}, 64'h2000, 64'd0, 1'b1, 1'b0, 0, "R5");
    i0 = find_log(1'b1, a, 64'd0, 0);
    i1 = find_log(1'b1, mk(10'h005, 3'd3, 12'h030), 64'd0, 0);
    check(i0 >= 0 && i1 > i0 && (txlog[i1].cyc - txlog[i0].cyc) >= SETTLE_CYC, "R5",
          "settle cycles before release", (i0 >= 0 && i1 > i0) ? txlog[i1].cyc - txlog[i0].cyc : 0, SETTLE_CYC);
    check(mem_rd(a) == 64'd0, "R5", "rate register cleared", mem_rd(a), 64'd0);

    // R6: enable with poll, ready on third read
    a = mk(10'h005, 3'd3, 12'h020);
    stat_pend_clear = 1'b0;
    stat_ready_after = 2;
    run_req(3'd3, {6'd0, a}, 64'h0F01, 64'd0, 1'b1, 1'b0, 0, "R6");
    check(stat_reads == 3, "R6", "status read count", stat_reads, 64'd3);
    gap_min = 1000;
    i0 = -1;
    for (int i = 0; i < txlog.size(); i++)
      if (!txlog[i].we && txlog[i].addr[11:0] == 12'h040) begin
        if (i0 >= 0 && txlog[i].cyc - txlog[i0].cyc < gap_min) gap_min = txlog[i].cyc - txlog[i0].cyc;
        i0 = i;
      end
    check(gap_min >= GAP + 1, "R6", "spacing of status reads", gap_min, GAP + 1);
    check(mem_rd(a) == 64'h0F01, "R6", "rate written after poll", mem_rd(a), 64'h0F01);

    // R6: connection-pending clear ends poll on first read
    stat_pend_clear = 1'b1;
    a = mk(10'h009, 3'd1, 12'h010);
    run_req(3'd1, {6'd0, a}, 64'h1, 64'd0, 1'b1, 1'b0, 0, "R6");
    check(stat_reads == 1, "R6", "single status read", stat_reads, 64'd1);
    stat_pend_clear = 1'b0;

    // R3: top-level committed is guarded, top-level peak is plain
    stat_ready_after = 0;
    a = mk(10'h002, 3'd4, 12'h010);
    run_req(3'd4, {6'd0, a}, 64'h3, 64'd0, 1'b1, 1'b0, 0, "R3");
    check(txlog.size() == 5, "R3", "top committed guarded", txlog.size(), 64'd5);
    a = mk(10'h002, 3'd4, 12'h020);
    run_req(3'd4, {6'd0, a}, 64'h3, 64'd0, 1'b1, 1'b0, 0, "R3");
    check(txlog.size() == 2, "R3", "top peak plain", txlog.size(), 64'd2);

    // R8: meta-descriptor level enable skips the poll
    a = mk(10'h004, 3'd0, 12'h010);
    run_req(3'd0, {6'd0, a}, 64'h9, 64'd0, 1'b1, 1'b0, 0, "R8");
    check(txlog.size() == 4 && stat_reads == 0, "R8", "no status read", stat_reads, 64'd0);
    a = mk(10'h004, 3'd0, 12'h020);
    mem[a] = 64'h1;
    run_req(3'd0, {6'd0, a}, 64'h0, 64'd0, 1'b1, 1'b0, 0, "R3");
    check(txlog.size() == 4, "R3", "meta-descriptor peak guarded", txlog.size(), 64'd4);

    // R7: poll timeout
    stat_ready_after = 1000000;
    a = mk(10'h001, 3'd2, 12'h020);
    run_req(3'd2, {6'd0, a}, 64'h7, 64'd0, 1'b1, 1'b1, 0, "R7");
    check(mem_rd(a) == 64'd0, "R7", "rate register untouched", mem_rd(a), 64'd0);
    i0 = find_log(1'b1, mk(10'h001, 3'd2, 12'h030), 64'd1, 0);
    i1 = find_log(1'b1, mk(10'h001, 3'd2, 12'h030), 64'd0, 0);
    check(i0 >= 0 && i1 > i0 && (txlog[i1].cyc - txlog[i0].cyc) >= TMO_CYC, "R7",
          "timeout length", (i0 >= 0 && i1 > i0) ? txlog[i1].cyc - txlog[i0].cyc : 0, TMO_CYC);
    stat_ready_after = 0;

    // R10: capability low gives plain write on a toggle
    a = mk(10'h001, 3'd2, 12'h010);
    run_req(3'd2, {6'd0, a}, 64'h11, 64'd0, 1'b0, 1'b0, 0, "R10");
    check(txlog.size() == 2 && mem_rd(a) == 64'h11, "R10", "plain merged write", mem_rd(a), 64'h11);

    // R11: response back-pressure
    a = mk(10'h00A, 3'd1, 12'h070);
    run_req(3'd1, {6'd0, a}, 64'hBEEF, 64'd0, 1'b1, 1'b0, 5, "R11");
    check(mem_rd(a) == 64'hBEEF, "R11", "write under back-pressure", mem_rd(a), 64'hBEEF);

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule